// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Readout Sequencer

This block takes over the control of an external six-channel parallel converter that samples all its channels at the same moment. It produces the converter's free-running conversion clock. On each start request it clears the converter's internal read pointer with a short active-low reset pulse. It then drops one shared active-low hold line, which freezes all six channels together. It waits for the converter's brief end-of-conversion pulse and reads the six 16-bit results over a chip-select/read bus.

The converter hands out results in a fixed order after its pointer reset, so no address decoding is needed. A channel index still goes out on three address lines. Each word is refreshed by the falling edge of its own read strobe. The sequencer samples the bus late in the strobe and presents the word with a valid flag, a channel tag and a last flag. After the sixth word it returns to idle and waits for the next start.

Top module: `sadc_seq`

## Requirements
- R1: After reset the converter reset, hold, chip-select and read outputs are all high and no sample is flagged valid. The block reports busy for SETTLE_CYC (16) cycles while the conversion clock settles, then drops busy.
- R2: The conversion clock runs freely with a period of CLK_DIV (12) system cycles and stays high for CLK_HI (6) of them.
- R3: A start pulse seen while idle drives the converter reset low for exactly RST_LOW_CYC (4) cycles. Reset and hold are never low together, and reset rises before hold falls.
- R4: Each frame has exactly one hold pulse. It is low for exactly HOLD_LOW_CYC (2) cycles, which is at least 20 ns at a 50 MHz system clock, and it only occurs while busy.
- R5: End-of-conversion is active low and is detected by its falling edge. A pulse only 2 system cycles long starts the readout. A low level that persists starts only one readout. A falling edge while idle or during a readout starts no read.
- R6: Each frame issues exactly six read strobes. Each strobe is low for exactly STROBE_CYC (3) cycles, and read is never low while chip select is high.
- R7: Words are delivered with a one-cycle valid flag, in channel order 0 to 5 (0=A0, 1=A1, 2=B0, 3=B1, 4=C0, 5=C1). Each carries the bus value present during its own strobe. Valid appears while read is still low, and read rises in the next cycle.
- R8: The last flag is set only together with the channel-5 word. Busy then drops, and no further strobe occurs until a new start.
- R9: A start pulse while busy is ignored. The frame still yields exactly six words and one hold pulse.
- R10: The address outputs carry the index of the word being read. The channel tag of each valid word equals that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one conversion frame (taken while idle) |
| busy | output | 1 | High from reset/start until the frame or settle time ends |
| adc_clk | output | 1 | Conversion clock to the converter |
| adc_rst_n | output | 1 | Active-low converter reset (clears read pointer) |
| adc_hold_n | output | 1 | Shared active-low hold for all six channels |
| adc_eoc_n | input | 1 | Active-low end-of-conversion pulse (asynchronous) |
| adc_cs_n | output | 1 | Active-low chip select |
| adc_rd_n | output | 1 | Active-low read strobe |
| adc_addr | output | 3 | Channel index of the word being read |
| adc_data | input | 16 | Converter parallel data bus |
| smp_valid | output | 1 | One-cycle flag for a captured word |
| smp_last | output | 1 | Set with the sixth word of a frame |
| smp_chan | output | 3 | Channel tag of the captured word |
| smp_data | output | 16 | Captured word |

## Verification
Two events can land in the same cycle. One is a stray end-of-conversion edge that arrives in the middle of a read burst, on top of a live strobe. The other is a start request that arrives while a frame is still running. The bench fires an extra short end-of-conversion pulse and a start pulse right after the first word is delivered. It then requires exactly six strobes, six correctly ordered words, a single hold pulse and a clean return to idle. An end-of-conversion edge that arrives while idle must produce no read strobe and no valid word.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    localparam int NUM_CH = 6;
    localparam int CH_W   = 3;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_IDLE,
        ST_PRST,
        ST_HOLD,
        ST_WAIT,
        ST_SETUP,
        ST_STROBE,
        ST_RECOV
    } seq_state_e;

endpackage

// File: rtl/sadc_clkgen.sv
module sadc_clkgen #(
    parameter int CLK_DIV = 12,
    parameter int CLK_HI  = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic conv_clk
);
    localparam int CW = $clog2(CLK_DIV + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ck;
    } cg_t;

    cg_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (r_q.cnt == CW'(CLK_DIV - 1)) r_d.cnt = '0;
        else                             r_d.cnt = r_q.cnt + 1'b1;
        r_d.ck = (r_d.cnt < CW'(CLK_HI));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cnt <= CW'(CLK_DIV - 1);
            r_q.ck  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign conv_clk = r_q.ck;

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt < CW'(CLK_DIV));

endmodule

// File: rtl/sadc_eoc_edge.sv
module sadc_eoc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic eoc_n_async,
    output logic eoc_fall
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sy_t;

    sy_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.s1   = eoc_n_async;
        r_d.s2   = r_q.s1;
        r_d.prev = r_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{s1: 1'b1, s2: 1'b1, prev: 1'b1};
        else        r_q <= r_d;
    end

    assign eoc_fall = r_q.prev & ~r_q.s2;

    assert_edge_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_fall |=> !eoc_fall);

endmodule

// File: rtl/sadc_rd_fsm.sv
module sadc_rd_fsm
    import sadc_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int SETTLE_CYC   = 16,
    parameter int RST_LOW_CYC  = 4,
    parameter int HOLD_LOW_CYC = 2,
    parameter int SETUP_CYC    = 1,
    parameter int STROBE_CYC   = 3,
    parameter int RECOV_CYC    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              eoc_fall,
    input  logic [DATA_W-1:0] bus_data,
    output logic              busy,
    output logic              conv_rst_n,
    output logic              hold_n,
    output logic              cs_n,
    output logic              rd_n,
    output logic [CH_W-1:0]   word_idx,
    output logic              out_valid,
    output logic              out_last,
    output logic [DATA_W-1:0] out_data
);
    localparam int MAXC = SETTLE_CYC + RST_LOW_CYC + HOLD_LOW_CYC
                        + SETUP_CYC + STROBE_CYC + RECOV_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CH_W-1:0] LAST_W = CH_W'(NUM_CH - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [CH_W-1:0]   word;
        logic              crst_n;
        logic              hold_n;
        logic              cs_n;
        logic              rd_n;
        logic              busy;
        logic              valid;
        logic              last;
        logic [DATA_W-1:0] data;
    } fsm_t;

    fsm_t r_q, r_d;

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.last  = 1'b0;
        r_d.cnt   = r_q.cnt + 1'b1;
        unique case (r_q.st)
            ST_INIT: begin
                if (r_q.cnt == CNT_W'(SETTLE_CYC - 1)) begin
                    r_d.st   = ST_IDLE;
                    r_d.busy = 1'b0;
                    r_d.cnt  = '0;
                end
            end
            ST_IDLE: begin
                r_d.cnt = '0;
                if (start) begin
                    r_d.st     = ST_PRST;
                    r_d.busy   = 1'b1;
                    r_d.crst_n = 1'b0;
                end
            end
            ST_PRST: begin
                if (r_q.cnt == CNT_W'(RST_LOW_CYC - 1)) begin
                    r_d.st     = ST_HOLD;
                    r_d.cnt    = '0;
                    r_d.crst_n = 1'b1;
                    r_d.hold_n = 1'b0;
                end
            end
            ST_HOLD: begin
                if (r_q.cnt == CNT_W'(HOLD_LOW_CYC - 1)) begin
                    r_d.st     = ST_WAIT;
                    r_d.cnt    = '0;
                    r_d.hold_n = 1'b1;
                end
            end
            ST_WAIT: begin
                r_d.cnt = '0;
                if (eoc_fall) begin
                    r_d.st   = ST_SETUP;
                    r_d.word = '0;
                    r_d.cs_n = 1'b0;
                end
            end
            ST_SETUP: begin
                if (r_q.cnt == CNT_W'(SETUP_CYC - 1)) begin
                    r_d.st   = ST_STROBE;
                    r_d.cnt  = '0;
                    r_d.rd_n = 1'b0;
                end
            end
            ST_STROBE: begin
                if (r_q.cnt == CNT_W'(STROBE_CYC - 2)) begin
                    r_d.valid = 1'b1;
                    r_d.last  = (r_q.word == LAST_W);
                    r_d.data  = bus_data;
                end
                if (r_q.cnt == CNT_W'(STROBE_CYC - 1)) begin
                    r_d.st   = ST_RECOV;
                    r_d.cnt  = '0;
                    r_d.rd_n = 1'b1;
                end
            end
            ST_RECOV: begin
                if (r_q.cnt == CNT_W'(RECOV_CYC - 1)) begin
                    r_d.cnt = '0;
                    if (r_q.word == LAST_W) begin
                        r_d.st   = ST_IDLE;
                        r_d.cs_n = 1'b1;
                        r_d.busy = 1'b0;
                    end else begin
                        r_d.st   = ST_SETUP;
                        r_d.word = r_q.word + 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= ST_INIT;
            r_q.crst_n <= 1'b1;
            r_q.hold_n <= 1'b1;
            r_q.cs_n   <= 1'b1;
            r_q.rd_n   <= 1'b1;
            r_q.busy   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = r_q.busy;
    assign conv_rst_n = r_q.crst_n;
    assign hold_n     = r_q.hold_n;
    assign cs_n       = r_q.cs_n;
    assign rd_n       = r_q.rd_n;
    assign word_idx   = r_q.word;
    assign out_valid  = r_q.valid;
    assign out_last   = r_q.last;
    assign out_data   = r_q.data;

    assert_rd_needs_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !cs_n);
    assert_valid_in_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !rd_n);
    assert_rd_rises_after_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> rd_n);
    assert_last_with_ch5_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (out_valid && word_idx == LAST_W));
    assert_hold_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_n |-> busy);
    assert_no_reset_with_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!hold_n && !conv_rst_n));
    assert_chan_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (word_idx < CH_W'(NUM_CH)));

endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
    import sadc_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int CLK_DIV      = 12,
    parameter int CLK_HI       = 6,
    parameter int SETTLE_CYC   = 16,
    parameter int RST_LOW_CYC  = 4,
    parameter int HOLD_LOW_CYC = 2,
    parameter int SETUP_CYC    = 1,
    parameter int STROBE_CYC   = 3,
    parameter int RECOV_CYC    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              adc_clk,
    output logic              adc_rst_n,
    output logic              adc_hold_n,
    input  logic              adc_eoc_n,
    output logic              adc_cs_n,
    output logic              adc_rd_n,
    output logic [2:0]        adc_addr,
    input  logic [DATA_W-1:0] adc_data,
    output logic              smp_valid,
    output logic              smp_last,
    output logic [2:0]        smp_chan,
    output logic [DATA_W-1:0] smp_data
);
    logic            eoc_fall;
    logic [CH_W-1:0] idx;

    sadc_clkgen #(.CLK_DIV(CLK_DIV), .CLK_HI(CLK_HI)) clkgen_i (
        .clk(clk), .rst_n(rst_n), .conv_clk(adc_clk)
    );

    sadc_eoc_edge eoc_i (
        .clk(clk), .rst_n(rst_n), .eoc_n_async(adc_eoc_n), .eoc_fall(eoc_fall)
    );

    sadc_rd_fsm #(
        .DATA_W(DATA_W), .SETTLE_CYC(SETTLE_CYC), .RST_LOW_CYC(RST_LOW_CYC),
        .HOLD_LOW_CYC(HOLD_LOW_CYC), .SETUP_CYC(SETUP_CYC),
        .STROBE_CYC(STROBE_CYC), .RECOV_CYC(RECOV_CYC)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .start(start), .eoc_fall(eoc_fall),
        .bus_data(adc_data), .busy(busy), .conv_rst_n(adc_rst_n),
        .hold_n(adc_hold_n), .cs_n(adc_cs_n), .rd_n(adc_rd_n),
        .word_idx(idx), .out_valid(smp_valid), .out_last(smp_last),
        .out_data(smp_data)
    );

    assign adc_addr = idx;
    assign smp_chan = idx;

endmodule

// File: tb/sadc_seq_tb.sv
module sadc_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        eoc_n = 1'b1;
    logic        busy, adc_clk, adc_rst_n, adc_hold_n, adc_cs_n, adc_rd_n;
    logic [2:0]  adc_addr, smp_chan;
    logic [15:0] adc_data, smp_data, buf_q;
    logic        smp_valid, smp_last;

    int n_tests = 0;
    int n_fail  = 0;
    int frame_id = 0;
    int ptr = 0;

    always #10 clk = ~clk;

    sadc_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
        .adc_clk(adc_clk), .adc_rst_n(adc_rst_n), .adc_hold_n(adc_hold_n),
        .adc_eoc_n(eoc_n), .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n),
        .adc_addr(adc_addr), .adc_data(adc_data), .smp_valid(smp_valid),
        .smp_last(smp_last), .smp_chan(smp_chan), .smp_data(smp_data)
    );

    function automatic logic [15:0] word_of(int f, int i);
        return 16'(16'h0F00 + f * 16'h0101 + i * 16'h1111);
    endfunction

    // converter model: pointer cleared by reset, buffer refreshed on read fall
    always @(negedge adc_rd_n or negedge adc_rst_n) begin
        if (!adc_rst_n) ptr = 0;
        else if (!adc_cs_n) begin
            buf_q = word_of(frame_id, ptr);
            ptr   = ptr + 1;
        end
    end
    assign adc_data = adc_cs_n ? 16'hDEAD : buf_q;

    // monitor
    int rd_run, rd_fall, rd_bad_len, rd_no_cs;
    int rst_run, rst_len, hold_run, hold_len, hold_falls, overlap;
    int n_val, val_err, addr_err, cap_err, last_err, pend_rise;
    logic prev_rd = 1'b1, prev_hold = 1'b1;
    logic [2:0]  got_ch [6];
    logic [15:0] got_d  [6];

    task automatic mon_clear();
        rd_run = 0; rd_fall = 0; rd_bad_len = 0; rd_no_cs = 0;
        rst_run = 0; rst_len = 0; hold_run = 0; hold_len = 0; hold_falls = 0;
        overlap = 0; n_val = 0; val_err = 0; addr_err = 0; cap_err = 0;
        last_err = 0; pend_rise = 0;
    endtask

    always @(negedge clk) begin
        if (pend_rise != 0 && adc_rd_n !== 1'b1) cap_err++;
        pend_rise = 0;
        if (!adc_rd_n && prev_rd) rd_fall++;
        if (!adc_rd_n) rd_run++;
        else if (rd_run != 0) begin if (rd_run != 3) rd_bad_len++; rd_run = 0; end
        if (!adc_rd_n && adc_cs_n) rd_no_cs++;
        if (!adc_rst_n) rst_run++;
        else if (rst_run != 0) begin rst_len = rst_run; rst_run = 0; end
        if (!adc_hold_n && prev_hold) begin
            hold_falls++;
            if (rst_len == 0) overlap++;
        end
        if (!adc_hold_n) hold_run++;
        else if (hold_run != 0) begin hold_len = hold_run; hold_run = 0; end
        if (!adc_hold_n && !adc_rst_n) overlap++;
        if (smp_valid) begin
            if (n_val < 6) begin got_ch[n_val] = smp_chan; got_d[n_val] = smp_data; end
            if (adc_rd_n !== 1'b0) cap_err++;
            pend_rise = 1;
            if (adc_addr != smp_chan) addr_err++;
            if (smp_last != (smp_chan == 3'd5)) last_err++;
            n_val++;
        end else if (smp_last) last_err++;
        prev_rd = adc_rd_n;
        prev_hold = adc_hold_n;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic fire_eoc(input int len);
        @(negedge clk) eoc_n = 1'b0;
        repeat (len) @(negedge clk);
        eoc_n = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(adc_rst_n && adc_hold_n && adc_cs_n && adc_rd_n, "R1", "strobes high",
            {adc_rst_n, adc_hold_n, adc_cs_n, adc_rd_n}, 15);
        chk(!smp_valid, "R1", "valid low", smp_valid, 0);
        chk(busy, "R1", "busy while settling", busy, 1);
        repeat (20) @(negedge clk);
        chk(!busy, "R1", "busy after settle", busy, 0);
    endtask

    task automatic t_clock();
        int hi = 0, lo = 0;
        while (adc_clk !== 1'b0) @(negedge clk);
        while (adc_clk !== 1'b1) @(negedge clk);
        while (adc_clk === 1'b1) begin hi++; @(negedge clk); end
        while (adc_clk === 1'b0) begin lo++; @(negedge clk); end
        chk(hi == 6, "R2", "clock high cycles", hi, 6);
        chk(hi + lo == 12, "R2", "clock period", hi + lo, 12);
    endtask

    task automatic run_frame(input int fid, input int eoc_len, input bit disturb);
        frame_id = fid;
        mon_clear();
        pulse_start();
        while (adc_hold_n !== 1'b0) @(negedge clk);
        while (adc_hold_n !== 1'b1) @(negedge clk);
        repeat (10) @(negedge clk);
        fire_eoc(eoc_len);
        if (disturb) begin
            while (smp_valid !== 1'b1) @(negedge clk);
            fork
                fire_eoc(2);
                pulse_start();
            join
        end
        while (busy !== 1'b0) @(negedge clk);
        repeat (30) @(negedge clk);
        chk(rst_len == 4, "R3", "converter reset width", rst_len, 4);
        chk(overlap == 0, "R3", "reset/hold overlap", overlap, 0);
        chk(hold_len == 2, "R4", "hold width", hold_len, 2);
        chk(hold_falls == 1, "R4", "hold pulses", hold_falls, 1);
        chk(rd_fall == 6, "R6", "read strobes", rd_fall, 6);
        chk(rd_bad_len == 0, "R6", "strobe length errors", rd_bad_len, 0);
        chk(rd_no_cs == 0, "R6", "read without cs", rd_no_cs, 0);
        chk(n_val == 6, "R7", "words", n_val, 6);
        chk(cap_err == 0, "R7", "capture timing errors", cap_err, 0);
        for (int i = 0; i < 6 && i < n_val; i++) begin
            chk(got_ch[i] == 3'(i), "R7", "channel order", got_ch[i], i);
            chk(got_d[i] == word_of(fid, i), "R7", "word data", got_d[i], word_of(fid, i));
        end
        chk(last_err == 0, "R8", "last flag errors", last_err, 0);
        chk(!busy && adc_cs_n, "R8", "idle after frame", busy, 0);
        chk(addr_err == 0, "R10", "address mismatch", addr_err, 0);
        if (disturb) chk(n_val == 6 && hold_falls == 1, "R9", "start while busy", n_val, 6);
        if (eoc_len > 8) chk(rd_fall == 6, "R5", "long eoc level", rd_fall, 6);
        else chk(n_val == 6, "R5", "short eoc pulse", n_val, 6);
    endtask

    task automatic t_idle_eoc();
        mon_clear();
        fire_eoc(3);
        repeat (40) @(negedge clk);
        chk(rd_fall == 0, "R5", "strobes from idle eoc", rd_fall, 0);
        chk(n_val == 0, "R5", "words from idle eoc", n_val, 0);
        chk(!busy, "R8", "stays idle without start", busy, 0);
    endtask

    initial begin
        t_reset();
        t_clock();
        run_frame(1, 2, 1'b0);
        run_frame(2, 6, 1'b0);
        run_frame(3, 30, 1'b0);
        run_frame(4, 2, 1'b1);
        t_idle_eoc();
        run_frame(5, 3, 1'b0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule